// File: doc/BRIEF.md
# Aperture Address Remapper

This block sits between a bus master and the interconnect and decides, for every address the master issues, which target slave receives the access and what address that slave sees. The 32-bit address space is split into 16 equal windows of 256 MB, chosen by the four top address bits. Every window carries two programmable fields: a slave number and a replacement window index. The block puts out the slave number and the address with its top four bits replaced by the programmed index. A window whose slave number is zero is unmapped, and an access to it raises a decode-error flag instead of selecting a slave.

Software programs the fields through a small 32-bit register port. Each write lands in a pending (shadow) copy, and the translation keeps using the active copy. A separate update write then moves the whole pending map into the active copy in a single cycle, so a map that is half rewritten is never seen by the master. Translation is registered: the result for an address shows up on the outputs one clock after that address is sampled.

Top module: `aper_remap`

## Requirements
- R1: After reset every window is unmapped: any address gives `map_err`=1 and `map_slave`=0, and every field register reads back as 0.
- R2: The slave numbers of windows 0..7 sit in the register at byte offset 0x0, and those of windows 8..15 at offset 0x4. Window k of a group uses bits 4(k mod 8)+3 down to 4(k mod 8).
- R3: The replacement indices use the same nibble packing, with windows 0..7 at offset 0x8 and windows 8..15 at offset 0xC.
- R4: Writes to offsets 0x0..0xC do not change the translation until an update write happens.
- R5: An update is a write to offset 0x10 with bit 0 set. A write to 0x10 with bit 0 clear has no effect on the translation.
- R6: A read at offsets 0x0..0xC returns the pending values, even before an update. A read at 0x10 returns 0. Read data appears on `cfg_rdata` on the clock after `cfg_rd` is sampled.
- R7: `map_addr` holds the window's replacement index in bits 31:28 and the input address bits 27:0 unchanged.
- R8: For a window with a nonzero slave number, `map_slave` equals that number and `map_err`=0. For a window with slave number 0, `map_err`=1 and `map_slave`=0.
- R9: The outputs are registered. They show the result for the `req_addr` sampled at the previous rising edge and hold it until the next edge.
- R10: One update copies all four field registers into the active map together. Windows whose pending fields did not change keep their mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after `cfg_rd` |
| req_addr | input | 32 | Address issued by the master |
| map_addr | output | 32 | Rewritten address |
| map_slave | output | 4 | Selected slave number, 0 when unmapped |
| map_err | output | 1 | Decode error: the window is unmapped |

## Verification
The bench goes after the point where pending and active copies split. It rewrites a field without an update and checks that translation stays on the old map while readback already shows the new value. A design that read back the active copy, or that let writes reach translation directly, fails there. A write of 0 to the update offset checks that a design firing on any write to that offset is caught. Windows at both ends of each packed register (0, 7, 8, 15), together with unmapped windows, catch nibble-order, register-swap and decode-error mistakes. A step that changes the input between edges catches an output path left combinational.

// File: rtl/aper_pkg.sv
package aper_pkg;

  // Word layout of the configuration port: slave words first, then
  // index words, then the update word.
  function automatic int unsigned words_per_table(input int unsigned naper,
                                                  input int unsigned field_w,
                                                  input int unsigned data_w);
    return (naper * field_w) / data_w;
  endfunction

  function automatic int unsigned upd_word(input int unsigned wpt);
    return 2 * wpt;
  endfunction

endpackage

// File: rtl/aper_regfile.sv
module aper_regfile
  import aper_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned NAPER   = 16,
  parameter int unsigned REG_AW  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr,
  input  logic                       cfg_rd,
  input  logic [REG_AW-1:0]          cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [DATA_W-1:0]          cfg_rdata,
  output logic [NAPER*FIELD_W-1:0]   pend_sel,
  output logic [NAPER*FIELD_W-1:0]   pend_idx,
  output logic                       upd_pulse
);

  localparam int unsigned WPT  = words_per_table(NAPER, FIELD_W, DATA_W);
  localparam int unsigned WI_W = REG_AW - 2;
  localparam logic [WI_W-1:0] UPD_IDX = WI_W'(upd_word(WPT));

  logic [WI_W-1:0]   widx;
  logic [DATA_W-1:0] sel_q [WPT];
  logic [DATA_W-1:0] idx_q [WPT];
  logic [DATA_W-1:0] rd_val;

  assign widx = cfg_addr[REG_AW-1:2];

  for (genvar w = 0; w < WPT; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[w] <= '0;
      end else if (cfg_wr && (widx == WI_W'(w))) begin
        sel_q[w] <= cfg_wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        idx_q[w] <= '0;
      end else if (cfg_wr && (widx == WI_W'(WPT + w))) begin
        idx_q[w] <= cfg_wdata;
      end
    end

    assign pend_sel[w*DATA_W +: DATA_W] = sel_q[w];
    assign pend_idx[w*DATA_W +: DATA_W] = idx_q[w];
  end

  assign upd_pulse = cfg_wr && (widx == UPD_IDX) && cfg_wdata[0];

  always_comb begin
    rd_val = '0;
    for (int w = 0; w < WPT; w++) begin
      if (widx == WI_W'(w))       rd_val = sel_q[w];
      if (widx == WI_W'(WPT + w)) rd_val = idx_q[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      cfg_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/aper_active.sv
module aper_active #(
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned NAPER   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd_pulse,
  input  logic [NAPER*FIELD_W-1:0] pend_sel,
  input  logic [NAPER*FIELD_W-1:0] pend_idx,
  output logic [NAPER*FIELD_W-1:0] act_sel,
  output logic [NAPER*FIELD_W-1:0] act_idx
);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel <= '0;
      act_idx <= '0;
    end else if (upd_pulse) begin
      act_sel <= pend_sel;
      act_idx <= pend_idx;
    end
  end

endmodule

// File: rtl/aper_decode.sv
module aper_decode #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned APER_BITS = 4,
  parameter int unsigned FIELD_W   = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic [(2**APER_BITS)*FIELD_W-1:0]    act_sel,
  input  logic [(2**APER_BITS)*FIELD_W-1:0]    act_idx,
  output logic [ADDR_W-1:0]                    map_addr,
  output logic [FIELD_W-1:0]                   map_slave,
  output logic                                 map_err
);

  localparam int unsigned NAPER = 2**APER_BITS;
  localparam int unsigned OFF_W = ADDR_W - APER_BITS;

  logic [FIELD_W-1:0]   sel_arr [NAPER];
  logic [FIELD_W-1:0]   idx_arr [NAPER];
  logic [APER_BITS-1:0] win;
  logic [FIELD_W-1:0]   hit_sel;
  logic [FIELD_W-1:0]   hit_idx;

  for (genvar a = 0; a < NAPER; a++) begin : g_win
    assign sel_arr[a] = act_sel[a*FIELD_W +: FIELD_W];
    assign idx_arr[a] = act_idx[a*FIELD_W +: FIELD_W];
  end

  assign win     = req_addr[ADDR_W-1 -: APER_BITS];
  assign hit_sel = sel_arr[win];
  assign hit_idx = idx_arr[win];

  always_ff @(posedge clk) begin
    if (rst) begin
      map_addr  <= '0;
      map_slave <= '0;
      map_err   <= 1'b1;
    end else begin
      map_addr  <= {hit_idx[APER_BITS-1:0], req_addr[OFF_W-1:0]};
      map_slave <= hit_sel;
      map_err   <= (hit_sel == '0);
    end
  end

endmodule

// File: rtl/aper_remap.sv
module aper_remap #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned APER_BITS = 4,
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_AW    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [REG_AW-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic [ADDR_W-1:0]  map_addr,
  output logic [FIELD_W-1:0] map_slave,
  output logic               map_err
);

  localparam int unsigned NAPER = 2**APER_BITS;
  localparam int unsigned MAP_W = NAPER * FIELD_W;

  logic [MAP_W-1:0] pend_sel;
  logic [MAP_W-1:0] pend_idx;
  logic [MAP_W-1:0] act_sel;
  logic [MAP_W-1:0] act_idx;
  logic             upd_pulse;

  aper_regfile #(
    .DATA_W (DATA_W),
    .FIELD_W(FIELD_W),
    .NAPER  (NAPER),
    .REG_AW (REG_AW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_rd   (cfg_rd),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .pend_sel (pend_sel),
    .pend_idx (pend_idx),
    .upd_pulse(upd_pulse)
  );

  aper_active #(
    .FIELD_W(FIELD_W),
    .NAPER  (NAPER)
  ) u_act (
    .clk      (clk),
    .rst      (rst),
    .upd_pulse(upd_pulse),
    .pend_sel (pend_sel),
    .pend_idx (pend_idx),
    .act_sel  (act_sel),
    .act_idx  (act_idx)
  );

  aper_decode #(
    .ADDR_W   (ADDR_W),
    .APER_BITS(APER_BITS),
    .FIELD_W  (FIELD_W)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .req_addr (req_addr),
    .act_sel  (act_sel),
    .act_idx  (act_idx),
    .map_addr (map_addr),
    .map_slave(map_slave),
    .map_err  (map_err)
  );

endmodule

// File: rtl/aper_remap_chk.sv
module aper_remap_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned APER_BITS = 4,
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_AW    = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_wr,
  input logic               cfg_rd,
  input logic [REG_AW-1:0]  cfg_addr,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic [DATA_W-1:0]  cfg_rdata,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [ADDR_W-1:0]  map_addr,
  input logic [FIELD_W-1:0] map_slave,
  input logic               map_err
);

  localparam int unsigned OFF_W   = ADDR_W - APER_BITS;
  localparam int unsigned WPT     = ((2**APER_BITS) * FIELD_W) / DATA_W;
  localparam logic [REG_AW-1:0] UPD_OFF = REG_AW'(8 * WPT);

  logic upd_wr;
  logic upd_rd;
  assign upd_wr = cfg_wr && (cfg_addr == UPD_OFF) && cfg_wdata[0];
  assign upd_rd = cfg_rd && (cfg_addr == UPD_OFF);

  // R1
  reset_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (map_err && (map_slave == '0)));

  // R4
  map_held_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && ($past(req_addr) == $past(req_addr, 2))
     && !$past(upd_wr, 2)) |-> ($stable(map_slave) && $stable(map_err)));

  // R7
  offset_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (map_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])));

  // R6
  upd_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(upd_rd) |-> (cfg_rdata == '0));

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !map_err |-> (map_slave != '0));

endmodule

bind aper_remap aper_remap_chk #(
  .ADDR_W   (ADDR_W),
  .APER_BITS(APER_BITS),
  .FIELD_W  (FIELD_W),
  .DATA_W   (DATA_W),
  .REG_AW   (REG_AW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_wr   (cfg_wr),
  .cfg_rd   (cfg_rd),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .req_addr (req_addr),
  .map_addr (map_addr),
  .map_slave(map_slave),
  .map_err  (map_err)
);

// File: tb/sim_aper_remap.sv
`timescale 1ns/1ps
module sim_aper_remap;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] req_addr = '0;
  logic [31:0] map_addr;
  logic [3:0]  map_slave;
  logic        map_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  aper_remap u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_addr(req_addr), .map_addr(map_addr), .map_slave(map_slave),
    .map_err(map_err)
  );

  // Map programmed by the bench (nibble k = window k of the group).
  localparam logic [31:0] SEL_LO = 32'h7000_2031;
  localparam logic [31:0] SEL_HI = 32'hF0E0_0045;
  localparam logic [31:0] IDX_LO = 32'h1000_0C9A;
  localparam logic [31:0] IDX_HI = 32'h60B0_0023;

  // {req_addr, slave, err, map_addr}
  localparam int NV = 11;
  localparam logic [68:0] VECS [NV] = '{
    {32'h0123_4567, 4'h1, 1'b0, 32'hA123_4567},
    {32'h1FFF_FFFF, 4'h3, 1'b0, 32'h9FFF_FFFF},
    {32'h2000_0010, 4'h0, 1'b1, 32'hC000_0010},
    {32'h3ABC_DEF0, 4'h2, 1'b0, 32'h0ABC_DEF0},
    {32'h7000_0000, 4'h7, 1'b0, 32'h1000_0000},
    {32'h8765_4321, 4'h5, 1'b0, 32'h3765_4321},
    {32'h9000_0001, 4'h4, 1'b0, 32'h2000_0001},
    {32'hD111_2222, 4'hE, 1'b0, 32'hB111_2222},
    {32'hE0F0_0F0F, 4'h0, 1'b1, 32'h00F0_0F0F},
    {32'hFFFF_FFFF, 4'hF, 1'b0, 32'h6FFF_FFFF},
    {32'h5555_5555, 4'h0, 1'b1, 32'h0555_5555}
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(posedge clk); #1;
    cfg_rd = 1'b0;
    n_chk++;
    if (cfg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read 0x%0h: got %h exp %h", req, a, cfg_rdata, exp);
    end
  endtask

  task automatic xl_chk(input logic [31:0] a, input logic [3:0] es, input logic ee,
                        input logic [31:0] ea, input string req);
    @(negedge clk);
    req_addr = a;
    @(posedge clk); #1;
    n_chk++;
    if (map_slave !== es || map_err !== ee || map_addr !== ea) begin
      n_bad++;
      $display("FAIL %s addr %h: got slave %h err %b addr %h exp slave %h err %b addr %h",
               req, a, map_slave, map_err, map_addr, es, ee, ea);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    xl_chk(32'h8765_4321, 4'h0, 1'b1, 32'h0765_4321, "R1");
    rd_chk(8'h00, 32'h0, "R1");
    rd_chk(8'h0C, 32'h0, "R1");

    // Program pending map; translation unchanged (R4), readback pending (R6)
    wr(8'h00, SEL_LO);
    wr(8'h04, SEL_HI);
    wr(8'h08, IDX_LO);
    wr(8'h0C, IDX_HI);
    xl_chk(32'h0123_4567, 4'h0, 1'b1, 32'h0123_4567, "R4");
    rd_chk(8'h00, SEL_LO, "R6 R2");
    rd_chk(8'h04, SEL_HI, "R6 R2");
    rd_chk(8'h08, IDX_LO, "R6 R3");
    rd_chk(8'h0C, IDX_HI, "R6 R3");

    // R5: update write with bit 0 clear ignored
    wr(8'h10, 32'hFFFF_FFFE);
    xl_chk(32'h0123_4567, 4'h0, 1'b1, 32'h0123_4567, "R5");

    // Real update, then walk vector table (R2 R3 R7 R8)
    wr(8'h10, 32'h1);
    for (int i = 0; i < NV; i++) begin
      xl_chk(VECS[i][68:37], VECS[i][36:33], VECS[i][32], VECS[i][31:0], "R2 R3 R7 R8");
    end
    rd_chk(8'h10, 32'h0, "R6");

    // R9: output held between edges
    xl_chk(32'h0000_0000, 4'h1, 1'b0, 32'hA000_0000, "R9");
    @(negedge clk);
    req_addr = 32'hF000_0000;
    #1;
    n_chk++;
    if (map_slave !== 4'h1 || map_addr !== 32'hA000_0000) begin
      n_bad++;
      $display("FAIL R9 between edges: got slave %h addr %h exp slave 1 addr a0000000",
               map_slave, map_addr);
    end
    @(posedge clk); #1;
    n_chk++;
    if (map_slave !== 4'hF || map_addr !== 32'h6000_0000) begin
      n_bad++;
      $display("FAIL R9 after edge: got slave %h addr %h exp slave f addr 60000000",
               map_slave, map_addr);
    end

    // Pending rewrite of low slave word: old map stays active (R4, R6)
    wr(8'h00, 32'h0);
    xl_chk(32'h0000_1234, 4'h1, 1'b0, 32'hA000_1234, "R4");
    rd_chk(8'h00, 32'h0, "R6");

    // R10: update applies; untouched words keep mapping
    wr(8'h10, 32'h1);
    xl_chk(32'h0000_1234, 4'h0, 1'b1, 32'hA000_1234, "R10");
    xl_chk(32'h8000_0008, 4'h5, 1'b0, 32'h3000_0008, "R10");
    xl_chk(32'hD000_0000, 4'hE, 1'b0, 32'hB000_0000, "R10");

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    xl_chk(32'hFFFF_FFFF, 4'h0, 1'b1, 32'h0FFF_FFFF, "R1");
    rd_chk(8'h04, 32'h0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule